// File: doc/BRIEF.md
# Post-Reset Configuration Byte Loader

After reset is released, this block fetches a small set of configuration bytes from memory. By default there are two. It then holds them as read-only configuration for the rest of the chip. It sends one read request per byte, always in ascending byte order. Each returned byte goes into its own register. When the last byte has arrived, the block raises a valid flag. From then on nothing changes until the next reset. Before that point, downstream logic sees every configuration bit at one and a low valid flag, and treats the configuration as not yet known.

The bytes live at fixed internal addresses. The first is at FF2018H and each later byte sits two bytes higher. Two strap inputs can place the bytes in external memory: a mode strap and a count of extended address lines. In that case only the low (16 + n) address bits reach the bus, where n is the number of extended lines in use, clamped to 8. The straps are sampled once, in the first cycle after reset. A register write port exists so that the block sits like any other register target, but every write is accepted and thrown away, and no error is reported.

Both halves of the memory interface use valid/ready. A request holds its valid and address steady until ready is seen, and only one read is outstanding at a time. The response side raises ready only while a byte is awaited. A response offered at any other time is not taken.

Top module: `cfg_boot_loader`

## Requirements
- R1: After reset is released, the block issues exactly one read per byte, in order byte 0 then byte 1. In internal mode (strap_ext_mode = 0) the addresses are FF2018H and FF201AH.
- R2: With strap_ext_mode = 1, the request address is the internal address with only its low (16 + n) bits kept, where n = min(strap_ext_lines, 8). The straps are sampled in the first cycle after reset, and later changes have no effect on the addresses.
- R3: While rd_req_valid is high and rd_req_ready is low, rd_req_valid stays high and rd_req_addr stays stable. After a request handshake, no new request is raised until that byte's response has been taken.
- R4: rd_rsp_ready is high only while a requested byte is awaited, never together with rd_req_valid. Response beats offered while it is low leave the configuration unchanged.
- R5: Byte k is stored in cfg_bytes[8k+7:8k]. cfg_valid goes high in the cycle right after the cycle whose rising edge completed the last response handshake, and the real values appear in that same cycle.
- R6: While cfg_valid is low, including during reset and mid-fetch, cfg_bytes reads all ones.
- R7: Once cfg_valid is high, it stays high, cfg_bytes stays constant, and no further request or response acceptance occurs until reset.
- R8: A pulse on reg_wr_en is answered by reg_wr_ack high in the next cycle with reg_wr_err low, and the write never alters cfg_bytes, whether it arrives before or after cfg_valid.
- R9: Asserting reset at any point, including mid-fetch, returns the outputs to their defaults. After release, the fetch restarts from byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_ext_mode | input | 1 | 1 = configuration bytes fetched from external memory |
| strap_ext_lines | input | LINES_W (4) | Number of extended address lines in use |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W (24) | Byte address of the read |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Block is awaiting a read byte |
| rd_rsp_data | input | DATA_W (8) | Returned byte |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | IDX_W (1) | Register write target |
| reg_wr_data | input | DATA_W (8) | Register write data (discarded) |
| reg_wr_ack | output | 1 | Write acknowledged, one cycle after the strobe |
| reg_wr_err | output | 1 | Write error flag, always low |
| cfg_bytes | output | N_CFG*DATA_W (16) | Configuration bytes, byte k at [8k+7:8k] |
| cfg_valid | output | 1 | Configuration loaded |

## Verification
The bench stalls request ready for several cycles and checks that the address does not drift. A design that dropped or changed its request early would show a moved address or a lost valid. Responses are offered while no byte is awaited, and the bench checks they are not taken. A loader that took them would store the junk byte or count it as a fetch step. The bench samples cfg_valid on both sides of the final handshake, because a one-cycle slip in the done timing or leaking a half-loaded register before done is the likely error. External mode runs with 0, 4, 7 and an over-range line count, and the straps are changed mid-fetch. Writes arrive both before and after the load, and a reset lands in the middle of a fetch. Together these expose wrong mask widths, a missing clamp, straps that are not latched, writable registers, and a restart that does not begin at byte 0.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  typedef enum logic [1:0] {
    ST_LAUNCH = 2'd0,
    ST_REQ    = 2'd1,
    ST_WAIT   = 2'd2,
    ST_LOADED = 2'd3
  } ld_state_e;

endpackage

// File: rtl/cfgld_addr_map.sv
module cfgld_addr_map #(
  parameter int ADDR_W     = 24,
  parameter int BASE_LINES = 16,
  parameter int LINES_W    = 4
) (
  input  logic               ext_mode,
  input  logic [LINES_W-1:0] ext_lines,
  input  logic [ADDR_W-1:0]  int_addr,
  output logic [ADDR_W-1:0]  bus_addr
);

  localparam int MAX_EXT = ADDR_W - BASE_LINES;

  int          ext_eff;
  int          keep_bits;
  logic [ADDR_W-1:0] keep_mask;

  always_comb begin
    ext_eff = int'(ext_lines);
    if (ext_eff > MAX_EXT) ext_eff = MAX_EXT;
    keep_bits = BASE_LINES + ext_eff;
  end

  for (genvar b = 0; b < ADDR_W; b++) begin : g_mask
    assign keep_mask[b] = (b < keep_bits);
  end

  assign bus_addr = ext_mode ? (int_addr & keep_mask) : int_addr;

endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
  import cfgld_pkg::*;
#(
  parameter int N_CFG = 2,
  localparam int IDX_W = (N_CFG > 1) ? $clog2(N_CFG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_ready,
  input  logic             rsp_valid,
  output logic             req_valid,
  output logic             rsp_ready,
  output logic [IDX_W-1:0] cur_idx,
  output logic             cap_en,
  output logic             strap_take,
  output logic             loaded
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CFG - 1);

  ld_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             last_byte;

  assign last_byte  = (idx_q == LAST_IDX);
  assign req_valid  = (state_q == ST_REQ);
  assign rsp_ready  = (state_q == ST_WAIT);
  assign cap_en     = rsp_ready && rsp_valid;
  assign strap_take = (state_q == ST_LAUNCH);
  assign loaded     = (state_q == ST_LOADED);
  assign cur_idx    = idx_q;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_LAUNCH: state_d = ST_REQ;
      ST_REQ:    if (req_ready) state_d = ST_WAIT;
      ST_WAIT: begin
        if (rsp_valid) begin
          if (last_byte) begin
            state_d = ST_LOADED;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = ST_REQ;
          end
        end
      end
      ST_LOADED: state_d = ST_LOADED;
      default:   state_d = ST_LAUNCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LAUNCH;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

endmodule

// File: rtl/cfgld_regs.sv
module cfgld_regs #(
  parameter int N_CFG  = 2,
  parameter int DATA_W = 8,
  localparam int IDX_W = (N_CFG > 1) ? $clog2(N_CFG) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_en,
  input  logic [IDX_W-1:0]        cap_idx,
  input  logic [DATA_W-1:0]       cap_data,
  input  logic                    loaded,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_sel,
  input  logic [DATA_W-1:0]       wr_data,
  output logic                    wr_ack,
  output logic                    wr_err,
  output logic [N_CFG*DATA_W-1:0] cfg_flat
);

  logic [DATA_W-1:0] cfg_q [N_CFG];

  for (genvar i = 0; i < N_CFG; i++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[i] <= '1;
      end else if (cap_en && (cap_idx == IDX_W'(i))) begin
        cfg_q[i] <= cap_data;
      end
    end
    // Outputs stay at the safe all-ones pattern until the whole set is in.
    assign cfg_flat[i*DATA_W +: DATA_W] = loaded ? cfg_q[i] : '1;
  end

  // The write beat is absorbed whole: every field takes part in the strobe
  // that completes the handshake, none reaches the configuration storage.
  logic wr_beat;
  assign wr_beat = wr_en & (|{wr_sel, wr_data, 1'b1});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_ack <= 1'b0;
    else        wr_ack <= wr_beat;
  end

  assign wr_err = 1'b0;

endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader #(
  parameter int          N_CFG      = 2,
  parameter int          DATA_W     = 8,
  parameter int          ADDR_W     = 24,
  parameter int          LINES_W    = 4,
  parameter int          BASE_LINES = 16,
  parameter int unsigned CFG_BASE   = 32'h00FF_2018,
  parameter int unsigned CFG_STRIDE = 2,
  localparam int IDX_W = (N_CFG > 1) ? $clog2(N_CFG) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    strap_ext_mode,
  input  logic [LINES_W-1:0]      strap_ext_lines,
  output logic                    rd_req_valid,
  input  logic                    rd_req_ready,
  output logic [ADDR_W-1:0]       rd_req_addr,
  input  logic                    rd_rsp_valid,
  output logic                    rd_rsp_ready,
  input  logic [DATA_W-1:0]       rd_rsp_data,
  input  logic                    reg_wr_en,
  input  logic [IDX_W-1:0]        reg_wr_sel,
  input  logic [DATA_W-1:0]       reg_wr_data,
  output logic                    reg_wr_ack,
  output logic                    reg_wr_err,
  output logic [N_CFG*DATA_W-1:0] cfg_bytes,
  output logic                    cfg_valid
);

  logic [IDX_W-1:0]   cur_idx;
  logic               cap_en;
  logic               strap_take;
  logic               loaded;
  logic               mode_q;
  logic [LINES_W-1:0] lines_q;
  logic [ADDR_W-1:0]  int_addr;

  cfgld_seq #(.N_CFG(N_CFG)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (rd_req_ready),
    .rsp_valid  (rd_rsp_valid),
    .req_valid  (rd_req_valid),
    .rsp_ready  (rd_rsp_ready),
    .cur_idx    (cur_idx),
    .cap_en     (cap_en),
    .strap_take (strap_take),
    .loaded     (loaded)
  );

  // Straps are frozen in the first cycle out of reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      lines_q <= '0;
    end else if (strap_take) begin
      mode_q  <= strap_ext_mode;
      lines_q <= strap_ext_lines;
    end
  end

  assign int_addr = ADDR_W'(CFG_BASE) + (ADDR_W'(cur_idx) * ADDR_W'(CFG_STRIDE));

  cfgld_addr_map #(
    .ADDR_W     (ADDR_W),
    .BASE_LINES (BASE_LINES),
    .LINES_W    (LINES_W)
  ) u_map (
    .ext_mode  (mode_q),
    .ext_lines (lines_q),
    .int_addr  (int_addr),
    .bus_addr  (rd_req_addr)
  );

  cfgld_regs #(.N_CFG(N_CFG), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .cap_idx  (cur_idx),
    .cap_data (rd_rsp_data),
    .loaded   (loaded),
    .wr_en    (reg_wr_en),
    .wr_sel   (reg_wr_sel),
    .wr_data  (reg_wr_data),
    .wr_ack   (reg_wr_ack),
    .wr_err   (reg_wr_err),
    .cfg_flat (cfg_bytes)
  );

  assign cfg_valid = loaded;

endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk #(
  parameter int N_CFG  = 2,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 24
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rd_req_valid,
  input logic                    rd_req_ready,
  input logic [ADDR_W-1:0]       rd_req_addr,
  input logic                    rd_rsp_valid,
  input logic                    rd_rsp_ready,
  input logic                    reg_wr_en,
  input logic                    reg_wr_ack,
  input logic                    reg_wr_err,
  input logic [N_CFG*DATA_W-1:0] cfg_bytes,
  input logic                    cfg_valid
);

  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  a_r4_rsp_only_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_ready |-> !rd_req_valid);

  a_r5_valid_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_valid) |-> $past(rd_rsp_valid && rd_rsp_ready));

  a_r6_default_ones: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |-> (cfg_bytes == '1));

  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> (cfg_valid && $stable(cfg_bytes)));

  a_r7_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (!rd_req_valid && !rd_rsp_ready));

  a_r8_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> (reg_wr_ack && !reg_wr_err));

endmodule

bind cfg_boot_loader cfgld_chk #(
  .N_CFG  (N_CFG),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .rd_rsp_valid (rd_rsp_valid),
  .rd_rsp_ready (rd_rsp_ready),
  .reg_wr_en    (reg_wr_en),
  .reg_wr_ack   (reg_wr_ack),
  .reg_wr_err   (reg_wr_err),
  .cfg_bytes    (cfg_bytes),
  .cfg_valid    (cfg_valid)
);

// File: tb/cfg_boot_loader_tb.sv
`timescale 1ns/1ps
module cfg_boot_loader_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_ext_mode = 1'b0;
  logic [3:0]  strap_ext_lines = '0;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b0;
  logic [23:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic        rd_rsp_ready;
  logic [7:0]  rd_rsp_data = '0;
  logic        reg_wr_en = 1'b0;
  logic [0:0]  reg_wr_sel = '0;
  logic [7:0]  reg_wr_data = '0;
  logic        reg_wr_ack;
  logic        reg_wr_err;
  logic [15:0] cfg_bytes;
  logic        cfg_valid;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  cfg_boot_loader u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .strap_ext_mode  (strap_ext_mode),
    .strap_ext_lines (strap_ext_lines),
    .rd_req_valid    (rd_req_valid),
    .rd_req_ready    (rd_req_ready),
    .rd_req_addr     (rd_req_addr),
    .rd_rsp_valid    (rd_rsp_valid),
    .rd_rsp_ready    (rd_rsp_ready),
    .rd_rsp_data     (rd_rsp_data),
    .reg_wr_en       (reg_wr_en),
    .reg_wr_sel      (reg_wr_sel),
    .reg_wr_data     (reg_wr_data),
    .reg_wr_ack      (reg_wr_ack),
    .reg_wr_err      (reg_wr_err),
    .cfg_bytes       (cfg_bytes),
    .cfg_valid       (cfg_valid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_addr(input int k, input bit mode, input int lines);
    logic [23:0] a;
    int n;
    a = 24'hFF2018 + 24'(2 * k);
    n = (lines > 8) ? 8 : lines;
    if (mode) a = a & ((24'h1 << (16 + n)) - 24'h1);
    return a;
  endfunction

  task automatic do_reset(input bit mode, input int lines);
    @(negedge clk);
    rst_n = 1'b0;
    rd_req_ready = 1'b0;
    rd_rsp_valid = 1'b0;
    strap_ext_mode = mode;
    strap_ext_lines = 4'(lines);
    repeat (2) @(negedge clk);
    // R6 R9: defaults held while in reset
    check(cfg_valid == 1'b0 && cfg_bytes == 16'hFFFF, "R6", "reset outputs",
          {15'd0, cfg_valid, cfg_bytes}, 32'h0000FFFF);
    check(rd_req_valid == 1'b0 && rd_rsp_ready == 1'b0, "R9", "bus idle in reset",
          {30'd0, rd_req_valid, rd_rsp_ready}, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic wait_req(output bit ok);
    ok = 1'b0;
    for (int t = 0; t < 50; t++) begin
      if (rd_req_valid) begin
        ok = 1'b1;
        return;
      end
      @(negedge clk);
    end
  endtask

  task automatic reg_write(input logic [0:0] sel, input logic [7:0] data,
                           input logic [15:0] exp_cfg);
    reg_wr_en = 1'b1;
    reg_wr_sel = sel;
    reg_wr_data = data;
    @(negedge clk);
    reg_wr_en = 1'b0;
    check(reg_wr_ack == 1'b1 && reg_wr_err == 1'b0, "R8", "write ack/err",
          {30'd0, reg_wr_ack, reg_wr_err}, 32'h2);
    @(negedge clk);
    check(cfg_bytes == exp_cfg, "R8", "write left config", cfg_bytes, exp_cfg);
  endtask

  // Serves the whole fetch; checks addresses, stalls, stray beats and done timing.
  task automatic serve(input bit mode, input int lines, input int req_lat,
                       input int rsp_lat, input bit stray, input bit wiggle,
                       input logic [7:0] b0, input logic [7:0] b1);
    bit ok;
    logic [23:0] ea;
    for (int k = 0; k < 2; k++) begin
      wait_req(ok);
      check(ok, "R1", "request seen", 32'(ok), 32'd1);
      if (!ok) return;
      ea = exp_addr(k, mode, lines);
      check(rd_req_addr == ea, mode ? "R2" : "R1", "request address", rd_req_addr, ea);
      if (wiggle && k == 0) strap_ext_lines = ~strap_ext_lines;
      for (int d = 0; d < req_lat; d++) begin
        if (stray) begin
          rd_rsp_valid = 1'b1;
          rd_rsp_data = 8'h5A;
        end
        @(negedge clk);
        check(rd_req_valid && rd_req_addr == ea, "R3", "request held under stall",
              rd_req_addr, ea);
        check(rd_rsp_ready == 1'b0, "R4", "no rsp ready while requesting",
              32'(rd_rsp_ready), 32'd0);
      end
      rd_rsp_valid = 1'b0;
      rd_req_ready = 1'b1;
      @(negedge clk);
      rd_req_ready = 1'b0;
      check(rd_req_valid == 1'b0 && rd_rsp_ready == 1'b1, "R3", "one outstanding read",
            {30'd0, rd_req_valid, rd_rsp_ready}, 32'h1);
      for (int d = 0; d < rsp_lat; d++) @(negedge clk);
      rd_rsp_valid = 1'b1;
      rd_rsp_data = k ? b1 : b0;
      check(cfg_valid == 1'b0 && cfg_bytes == 16'hFFFF, "R6", "ones before last edge",
            {15'd0, cfg_valid, cfg_bytes}, 32'h0000FFFF);
      @(negedge clk);
      rd_rsp_valid = 1'b0;
      if (k == 1) begin
        check(cfg_valid == 1'b1 && cfg_bytes == {b1, b0}, "R5", "loaded next cycle",
              {15'd0, cfg_valid, cfg_bytes}, {15'd0, 1'b1, b1, b0});
      end else begin
        check(cfg_valid == 1'b0 && cfg_bytes == 16'hFFFF, "R6", "half load hidden",
              {15'd0, cfg_valid, cfg_bytes}, 32'h0000FFFF);
      end
    end
  endtask

  task automatic hold_check(input logic [15:0] exp_cfg);
    for (int c = 0; c < 8; c++) begin
      rd_rsp_valid = (c == 3);
      rd_rsp_data = 8'hC3;
      rd_req_ready = (c == 5);
      @(negedge clk);
    end
    rd_rsp_valid = 1'b0;
    rd_req_ready = 1'b0;
    check(cfg_valid && cfg_bytes == exp_cfg && !rd_req_valid && !rd_rsp_ready,
          "R7", "frozen after load", cfg_bytes, exp_cfg);
  endtask

  task automatic t_internal;
    do_reset(1'b0, 0);
    serve(1'b0, 0, 0, 0, 1'b0, 1'b0, 8'hA5, 8'h3C);
    hold_check(16'h3CA5);
  endtask

  task automatic t_ext_zero_lines;
    do_reset(1'b1, 0);
    serve(1'b1, 0, 3, 2, 1'b1, 1'b0, 8'h00, 8'h81);
    hold_check(16'h8100);
  endtask

  task automatic t_ext_four_latched;
    do_reset(1'b1, 4);
    serve(1'b1, 4, 1, 1, 1'b0, 1'b1, 8'h12, 8'h34);
  endtask

  task automatic t_ext_seven;
    do_reset(1'b1, 7);
    serve(1'b1, 7, 0, 3, 1'b1, 1'b0, 8'h7E, 8'hE7);
  endtask

  task automatic t_ext_clamp;
    do_reset(1'b1, 12);
    serve(1'b1, 12, 2, 0, 1'b0, 1'b0, 8'h01, 8'h02);
  endtask

  task automatic t_writes;
    bit ok;
    do_reset(1'b0, 0);
    wait_req(ok);
    // R8: writes before load leave the defaults
    reg_write(1'b0, 8'h00, 16'hFFFF);
    reg_write(1'b1, 8'h55, 16'hFFFF);
    serve(1'b0, 0, 0, 1, 1'b0, 1'b0, 8'hC0, 8'hDE);
    reg_write(1'b0, 8'hFF, 16'hDEC0);
    reg_write(1'b1, 8'h00, 16'hDEC0);
  endtask

  task automatic t_reset_mid;
    bit ok;
    do_reset(1'b0, 0);
    wait_req(ok);
    rd_req_ready = 1'b1;
    @(negedge clk);
    rd_req_ready = 1'b0;
    rd_rsp_valid = 1'b1;
    rd_rsp_data = 8'h99;
    @(negedge clk);
    rd_rsp_valid = 1'b0;
    // R9: abort mid fetch, restart from byte 0
    do_reset(1'b0, 0);
    serve(1'b0, 0, 0, 0, 1'b0, 1'b0, 8'h44, 8'h66);
  endtask

  initial begin
    #(200000 * 20);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_internal();
    t_ext_zero_lines();
    t_ext_four_latched();
    t_ext_seven();
    t_ext_clamp();
    t_writes();
    t_reset_mid();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule